// File: doc/BRIEF.md
# Registered 12/24-bit Bus Multiplexing Transceiver

This block joins a narrow 12-bit port (side A) to a pair of 12-bit ports (B-low and B-high). Taken together, the two B ports can serve as one 24-bit port. In the A-to-B direction, each B half has its own capture register. Each register takes the A word on a rising clock edge when its own active-low load strobe is low. If the strobes are asserted on consecutive cycles, two successive A words end up side by side on B, where they read as one 24-bit value. In the B-to-A direction, a single register loads on every rising edge. It takes B-low when the select input is high and B-high when the select is low.

All three output drive controls are active low and are registered on the clock, so a change on any of them shows at the port only after the next rising edge. Each port is a tri-state pin, modelled here as a data-out bus plus a drive-enable bit. The drive enable is active high and shows that the port is driving. The three ports are enabled independently, so A and both B halves may all drive at the same time. The asynchronous active-low reset is released synchronously through a two-stage synchronizer. While reset is applied, every data register holds zero and no port drives.

Top module: `bus_split_xcvr`

## Requirements
- R1: On a rising edge with `blo_load_n` low, `blo_dout` takes the value of `a_din`.
- R2: On a rising edge with `bhi_load_n` low, `bhi_dout` takes the value of `a_din`.
- R3: On a rising edge with a B load strobe high, that B half's `*_dout` keeps its previous value.
- R4: On every rising edge, `a_dout` loads `blo_din` if `pick_lo` is 1 and `bhi_din` if `pick_lo` is 0. It has no load enable.
- R5: Each drive enable output is the inverse of its active-low control (`a_hold_n`, `blo_hold_n`, `bhi_hold_n`) as sampled at the latest rising edge. A change between edges does not show until the next edge.
- R6: The three drive enables are independent of one another, and of the data path. All eight combinations, including all three driving at once, are reachable. Data registers load whether or not their port is driving.
- R7: Driving `blo_load_n` low with word W0, then `bhi_load_n` low with word W1 on the next cycle, gives {`bhi_dout`,`blo_dout`} = {W1,W0}. This value holds while both strobes stay high.
- R8: While reset is applied (`rst_n` low, asynchronous), all data outputs are 0 and all drive enables are 0. Normal loading resumes on the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every transfer happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_din | input | 12 | Value received on side A |
| a_dout | output | 12 | Value side A drives when enabled |
| a_drive | output | 1 | Side A drive enable (1 = driving) |
| blo_din | input | 12 | Value received on B-low |
| blo_dout | output | 12 | B-low capture register |
| blo_drive | output | 1 | B-low drive enable |
| bhi_din | input | 12 | Value received on B-high |
| bhi_dout | output | 12 | B-high capture register |
| bhi_drive | output | 1 | B-high drive enable |
| blo_load_n | input | 1 | Active-low load strobe for B-low |
| bhi_load_n | input | 1 | Active-low load strobe for B-high |
| pick_lo | input | 1 | 1 selects B-low, 0 selects B-high, as the source for A |
| a_hold_n | input | 1 | Active-low drive control for side A (registered) |
| blo_hold_n | input | 1 | Active-low drive control for B-low (registered) |
| bhi_hold_n | input | 1 | Active-low drive control for B-high (registered) |

## Verification
The bench sweeps all 64 combinations of the six control inputs, several times over, with data patterns it computes. The sweep catches a design with swapped or shared load strobes: that design would change the wrong B half or both halves. It also catches an inverted select, which would route the wrong B half to A. Between the drive of new control values and the next rising edge, the bench checks that the drive enables still show the old value. A design that left the drive controls combinational would fail that check. The bench also builds a 24-bit word from two consecutive A words, and it applies reset during traffic to confirm that every output clears at once and stays silent.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int PORT_A     = 0;
  localparam int PORT_BLO   = 1;
  localparam int PORT_BHI   = 2;
  localparam int NUM_PORTS  = 3;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[DEPTH-1];
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/xcvr_oe_bank.sv
module xcvr_oe_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hold_n,
  output logic [N-1:0] drive
);
  for (genvar g = 0; g < N; g++) begin : g_oe
    logic drv_next;
    always_comb begin
      drv_next = ~hold_n[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drive[g] <= 1'b0;
      else        drive[g] <= drv_next;
    end
  end
endmodule

// File: rtl/bus_split_xcvr.sv
module bus_split_xcvr #(
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] a_din,
  output logic [HALF_W-1:0] a_dout,
  output logic              a_drive,
  input  logic [HALF_W-1:0] blo_din,
  output logic [HALF_W-1:0] blo_dout,
  output logic              blo_drive,
  input  logic [HALF_W-1:0] bhi_din,
  output logic [HALF_W-1:0] bhi_dout,
  output logic              bhi_drive,
  input  logic              blo_load_n,
  input  logic              bhi_load_n,
  input  logic              pick_lo,
  input  logic              a_hold_n,
  input  logic              blo_hold_n,
  input  logic              bhi_hold_n
);
  import xcvr_pkg::*;

  logic                 rst_q_n;
  logic [NUM_PORTS-1:0] hold_vec_n;
  logic [NUM_PORTS-1:0] drive_vec;
  logic [HALF_W-1:0]    a_src;
  logic                 blo_load;
  logic                 bhi_load;

  xcvr_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  always_comb begin
    hold_vec_n           = '1;
    hold_vec_n[PORT_A]   = a_hold_n;
    hold_vec_n[PORT_BLO] = blo_hold_n;
    hold_vec_n[PORT_BHI] = bhi_hold_n;
    blo_load             = ~blo_load_n;
    bhi_load             = ~bhi_load_n;
    a_src                = pick_lo ? blo_din : bhi_din;
  end

  xcvr_oe_bank #(.N(NUM_PORTS)) u_oe (
    .clk(clk), .rst_n(rst_q_n), .hold_n(hold_vec_n), .drive(drive_vec)
  );

  xcvr_cap_reg #(.W(HALF_W)) u_blo (
    .clk(clk), .rst_n(rst_q_n), .load(blo_load), .d(a_din), .q(blo_dout)
  );

  xcvr_cap_reg #(.W(HALF_W)) u_bhi (
    .clk(clk), .rst_n(rst_q_n), .load(bhi_load), .d(a_din), .q(bhi_dout)
  );

  xcvr_cap_reg #(.W(HALF_W)) u_a (
    .clk(clk), .rst_n(rst_q_n), .load(1'b1), .d(a_src), .q(a_dout)
  );

  assign a_drive   = drive_vec[PORT_A];
  assign blo_drive = drive_vec[PORT_BLO];
  assign bhi_drive = drive_vec[PORT_BHI];
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_din,
  input logic [W-1:0] a_dout,
  input logic         a_drive,
  input logic [W-1:0] blo_din,
  input logic [W-1:0] blo_dout,
  input logic         blo_drive,
  input logic [W-1:0] bhi_din,
  input logic [W-1:0] bhi_dout,
  input logic         bhi_drive,
  input logic         blo_load_n,
  input logic         bhi_load_n,
  input logic         pick_lo,
  input logic         a_hold_n,
  input logic         blo_hold_n,
  input logic         bhi_hold_n
);
  a_r1_blo_load: assert property (@(posedge clk) disable iff (!rst_n)
    !blo_load_n |=> blo_dout == $past(a_din));
  a_r2_bhi_load: assert property (@(posedge clk) disable iff (!rst_n)
    !bhi_load_n |=> bhi_dout == $past(a_din));
  a_r3_blo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    blo_load_n |=> $stable(blo_dout));
  a_r3_bhi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bhi_load_n |=> $stable(bhi_dout));
  a_r4_pick_lo: assert property (@(posedge clk) disable iff (!rst_n)
    pick_lo |=> a_dout == $past(blo_din));
  a_r4_pick_hi: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_lo |=> a_dout == $past(bhi_din));
  a_r5_a_on: assert property (@(posedge clk) disable iff (!rst_n)
    !a_hold_n |=> a_drive);
  a_r5_a_off: assert property (@(posedge clk) disable iff (!rst_n)
    a_hold_n |=> !a_drive);
  a_r6_blo_drive: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> blo_drive == !$past(blo_hold_n));
  a_r6_bhi_drive: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bhi_drive == !$past(bhi_hold_n));
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (a_dout == '0 && blo_dout == '0 && bhi_dout == '0 &&
                !a_drive && !blo_drive && !bhi_drive));
endmodule

bind bus_split_xcvr xcvr_checker #(.W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n),
  .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
  .blo_din(blo_din), .blo_dout(blo_dout), .blo_drive(blo_drive),
  .bhi_din(bhi_din), .bhi_dout(bhi_dout), .bhi_drive(bhi_drive),
  .blo_load_n(blo_load_n), .bhi_load_n(bhi_load_n), .pick_lo(pick_lo),
  .a_hold_n(a_hold_n), .blo_hold_n(blo_hold_n), .bhi_hold_n(bhi_hold_n)
);

// File: tb/test_bus_split_xcvr.sv
module test_bus_split_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_din, blo_din, bhi_din;
  logic [W-1:0] a_dout, blo_dout, bhi_dout;
  logic a_drive, blo_drive, bhi_drive;
  logic blo_load_n, bhi_load_n, pick_lo, a_hold_n, blo_hold_n, bhi_hold_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_a, m_blo, m_bhi;
  logic m_da, m_dlo, m_dhi;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_split_xcvr #(.HALF_W(W)) i_bus_split_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
    .blo_din(blo_din), .blo_dout(blo_dout), .blo_drive(blo_drive),
    .bhi_din(bhi_din), .bhi_dout(bhi_dout), .bhi_drive(bhi_drive),
    .blo_load_n(blo_load_n), .bhi_load_n(bhi_load_n), .pick_lo(pick_lo),
    .a_hold_n(a_hold_n), .blo_hold_n(blo_hold_n), .bhi_hold_n(bhi_hold_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // control word bits: [0] blo_load_n [1] bhi_load_n [2] pick_lo
  // [3] a_hold_n [4] blo_hold_n [5] bhi_hold_n
  task automatic drive_in(input logic [5:0] c, input logic [W-1:0] a,
                          input logic [W-1:0] lo, input logic [W-1:0] hi);
    {bhi_hold_n, blo_hold_n, a_hold_n, pick_lo, bhi_load_n, blo_load_n} = c;
    a_din = a; blo_din = lo; bhi_din = hi;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R1 blo_dout"}, blo_dout, m_blo);
    chk({tag, " R2 bhi_dout"}, bhi_dout, m_bhi);
    chk({tag, " R4 a_dout"},   a_dout,   m_a);
    chk({tag, " R6 a_drive"},   {11'd0, a_drive},   {11'd0, m_da});
    chk({tag, " R6 blo_drive"}, {11'd0, blo_drive}, {11'd0, m_dlo});
    chk({tag, " R6 bhi_drive"}, {11'd0, bhi_drive}, {11'd0, m_dhi});
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [5:0] c, input logic [W-1:0] a,
                      input logic [W-1:0] lo, input logic [W-1:0] hi, input string tag);
    drive_in(c, a, lo, hi);
    #1;
    // R5: new control values do not reach the drive enables before an edge
    chk({tag, " R5 a_drive pre-edge"},   {11'd0, a_drive},   {11'd0, m_da});
    chk({tag, " R5 blo_drive pre-edge"}, {11'd0, blo_drive}, {11'd0, m_dlo});
    chk({tag, " R5 bhi_drive pre-edge"}, {11'd0, bhi_drive}, {11'd0, m_dhi});
    @(posedge clk);
    if (!c[0]) m_blo = a;        // R1
    if (!c[1]) m_bhi = a;        // R2, R3 hold otherwise
    m_a   = c[2] ? lo : hi;      // R4
    m_da  = !c[3];
    m_dlo = !c[4];
    m_dhi = !c[5];
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic check_reset(input string tag);
    chk({tag, " R8 a_dout"},   a_dout,   '0);
    chk({tag, " R8 blo_dout"}, blo_dout, '0);
    chk({tag, " R8 bhi_dout"}, bhi_dout, '0);
    chk({tag, " R8 drives"}, {9'd0, a_drive, blo_drive, bhi_drive}, '0);
  endtask

  task automatic do_reset(input string tag);
    drive_in(6'b111011, '0, '0, '0);
    rst_n = 1'b0;
    #1;
    check_reset({tag, " async"});
    @(negedge clk);
    @(negedge clk);
    check_reset({tag, " held"});
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_a = '0; m_blo = '0; m_bhi = '0;
    m_da = 1'b0; m_dlo = 1'b0; m_dhi = 1'b0;
    check_all({tag, " R8 after release"});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b1;
    drive_in(6'b111011, '0, '0, '0);
    #1;
    @(negedge clk);
    do_reset("init");

    // Sweep every control combination with computed data
    for (int i = 0; i < 256; i++) begin
      logic [5:0] c;
      logic [W-1:0] a, lo, hi;
      c  = 6'(i ^ (i >> 6) * 21);
      a  = W'(i * 37 + 5);
      lo = W'(i * 1103 + 91);
      hi = W'(~(i * 613 + 7));
      step(c, a, lo, hi, "sweep");
    end

    // R3: both strobes high, A word changes, B halves hold
    step(6'b000011, 12'hABC, 12'h111, 12'h222, "R3 hold");
    step(6'b000111, 12'h5A5, 12'h333, 12'h444, "R3 hold2");

    // R7: two consecutive words form one 24-bit value
    step(6'b000110, 12'h123, 12'h0F0, 12'h00F, "R7 w0");
    step(6'b000101, 12'h456, 12'h0F0, 12'h00F, "R7 w1");
    step(6'b000011, 12'hFFF, 12'h0F0, 12'h00F, "R7 idle");
    chk("R7 wide word", blo_dout, 12'h123);
    chk("R7 wide word high", bhi_dout, 12'h456);

    // R6: all three ports driving at once, then mid-traffic reset
    step(6'b000000, 12'h777, 12'h999, 12'h888, "R6 all on");
    do_reset("mid");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule